// File: doc/BRIEF.md
# Digital Potentiometer Wiper Controller

This block is the control logic for one channel of an up/down-stepped digital potentiometer. A host drives three inputs: an active-low channel select, an increment strobe and a direction level. All three are sampled on the system clock through a two-flop synchronizer. While the channel is selected, each high-to-low transition of the strobe moves a wiper position counter one step. The step is up when the direction level is high and down when it is low. The counter stops at either end of its range instead of wrapping. The position drives a registered one-hot tap-select vector with one bit per resistor tap.

A register stands in for nonvolatile storage. The strobe level at the moment the host releases select decides between two outcomes:
- If the strobe is high, the current position is written into the storage register. The channel then reports busy for a fixed number of clock cycles before it settles into standby.
- If the strobe is low, nothing is written and the channel goes straight back to standby, keeping its position.

Reset acts as power-up. The storage register keeps its content across reset, and the counter reloads from it. A dual-channel part is built from two independent instances.

Top module: `potwiper_ctrl`

## Requirements
- R1: `tap_sel_o` has exactly one bit set after reset. That bit is bit number `wiper_pos_o` (bit 0 is tap 0, bit 31 is tap 31).
- R2: The position moves only on a high-to-low transition of `inc_i` while `sel_n_i` is low. Strobe activity while `sel_n_i` is high leaves the position unchanged.
- R3: With `up_i` = 1 a strobe fall adds one to the position, and with `up_i` = 0 it subtracts one. `up_i` may change between strobe falls while the channel stays selected.
- R4: A step up at position 31 leaves the position at 31, and a step down at position 0 leaves it at 0.
- R5: A low-to-high transition of `sel_n_i` while `inc_i` is high copies the position into the storage register. `busy_o` is then high for exactly STORE_CYC consecutive cycles.
- R6: A low-to-high transition of `sel_n_i` while `inc_i` is low writes nothing and raises no busy period. The position is kept.
- R7: While `rst_n` is low, the position loads the storage register content. That content survives reset and starts as NV_INIT (16 by default).
- R8: While `busy_o` is high, select and strobe activity are ignored and the position holds. `standby_o` is high only when the channel is deselected and not busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset, acts as power-up recall |
| sel_n_i | input | 1 | Active-low channel select, asynchronous |
| inc_i | input | 1 | Increment strobe, moves on its falling edge, asynchronous |
| up_i | input | 1 | Step direction, 1 = up, 0 = down, asynchronous |
| wiper_pos_o | output | POS_W | Current wiper position |
| tap_sel_o | output | 2**POS_W | Registered one-hot tap select |
| busy_o | output | 1 | High during the store period |
| standby_o | output | 1 | High when deselected and not storing |

## Verification
The bound checker checks these on every cycle:
- the tap vector stays one-hot and matches the position;
- the position never changes without a detected strobe fall, and never changes during a busy period;
- each detected fall steps by exactly one in the direction sampled, and holds at the two ends;
- a store decision raises busy, and a no-store decision does not;
- each busy run lasts exactly the configured length.

Other behaviour can only be shown by the bench's scenarios at the ports. This covers that strobe pulses while deselected are ignored, and that a no-store release leaves the stored value alone. It also covers that the value written by a store, and not the last live position, is what a later reset brings back.

// File: rtl/pw_pkg.sv
package pw_pkg;

  typedef enum logic [1:0] {
    CH_STANDBY = 2'd0,
    CH_ACTIVE  = 2'd1,
    CH_STORING = 2'd2
  } ch_state_e;

  // One saturating step of the wiper position within [0, top].
  function automatic int unsigned sat_step(input int unsigned pos,
                                           input logic up_dir,
                                           input int unsigned top);
    if (up_dir) return (pos >= top) ? top : pos + 1;
    return (pos == 0) ? 0 : pos - 1;
  endfunction

endpackage

// File: rtl/pw_sync.sv
module pw_sync #(
  parameter int unsigned WIDTH = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pw_step_ctrl.sv
module pw_step_ctrl #(
  parameter int unsigned POS_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_s_i,
  input  logic             up_s_i,
  input  logic             active_i,
  input  logic [POS_W-1:0] recall_i,
  output logic             fall_o,
  output logic [POS_W-1:0] pos_next_o,
  output logic [POS_W-1:0] pos_o
);
  localparam int unsigned POS_MAX = (1 << POS_W) - 1;

  logic             inc_d_q;
  logic [POS_W-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (!rst_n) inc_d_q <= 1'b1;
    else        inc_d_q <= inc_s_i;
  end

  assign fall_o = active_i & inc_d_q & ~inc_s_i;

  always_comb begin
    if (!rst_n)
      pos_next_o = recall_i;
    else if (fall_o)
      pos_next_o = POS_W'(pw_pkg::sat_step(32'(pos_q), up_s_i, POS_MAX));
    else
      pos_next_o = pos_q;
  end

  always_ff @(posedge clk) pos_q <= pos_next_o;

  assign pos_o = pos_q;
endmodule

// File: rtl/pw_tap_decode.sv
module pw_tap_decode #(
  parameter int unsigned POS_W = 5,
  localparam int unsigned TAPS = 1 << POS_W
) (
  input  logic             clk,
  input  logic [POS_W-1:0] pos_next_i,
  output logic [TAPS-1:0]  tap_o
);
  logic [TAPS-1:0] tap_q;

  always_ff @(posedge clk) tap_q <= TAPS'(1) << pos_next_i;

  assign tap_o = tap_q;
endmodule

// File: rtl/pw_store_ctrl.sv
module pw_store_ctrl #(
  parameter int unsigned POS_W = 5,
  parameter int unsigned STORE_CYC = 16,
  parameter logic [POS_W-1:0] NV_INIT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_s_i,
  input  logic             inc_s_i,
  input  logic [POS_W-1:0] pos_i,
  output logic [POS_W-1:0] nv_o,
  output logic             sel_rise_o,
  output logic             store_go_o,
  output logic             active_o,
  output logic             busy_o,
  output logic             standby_o
);
  import pw_pkg::*;

  localparam int unsigned CNT_W = $clog2(STORE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STORE_CYC - 1);

  ch_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  // Stand-in for nonvolatile cells: not cleared by reset.
  logic [POS_W-1:0] nv_q = NV_INIT;

  assign active_o   = (state_q == CH_ACTIVE);
  assign busy_o     = (state_q == CH_STORING);
  assign standby_o  = (state_q == CH_STANDBY);
  assign sel_rise_o = active_o & sel_s_i;
  assign store_go_o = sel_rise_o & inc_s_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= CH_STANDBY;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        CH_STANDBY: if (!sel_s_i) state_q <= CH_ACTIVE;
        CH_ACTIVE: begin
          if (store_go_o) begin
            state_q <= CH_STORING;
            cnt_q   <= CNT_LOAD;
          end else if (sel_rise_o) begin
            state_q <= CH_STANDBY;
          end
        end
        CH_STORING: begin
          if (cnt_q == '0) state_q <= sel_s_i ? CH_STANDBY : CH_ACTIVE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= CH_STANDBY;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && store_go_o) nv_q <= pos_i;
  end

  assign nv_o = nv_q;
endmodule

// File: rtl/potwiper_ctrl.sv
module potwiper_ctrl #(
  parameter int unsigned POS_W = 5,
  parameter int unsigned STORE_CYC = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned NV_INIT = 16,
  localparam int unsigned TAPS = 1 << POS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n_i,
  input  logic             inc_i,
  input  logic             up_i,
  output logic [POS_W-1:0] wiper_pos_o,
  output logic [TAPS-1:0]  tap_sel_o,
  output logic             busy_o,
  output logic             standby_o
);
  logic [2:0]       sync_w;
  logic             sel_s_w, inc_s_w, up_s_w;
  logic             inc_fall_w, sel_rise_w, store_go_w, active_w;
  logic [POS_W-1:0] pos_next_w, nv_w;

  pw_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({sel_n_i, inc_i, up_i}), .q_o(sync_w)
  );
  assign {sel_s_w, inc_s_w, up_s_w} = sync_w;

  pw_store_ctrl #(.POS_W(POS_W), .STORE_CYC(STORE_CYC),
                  .NV_INIT(POS_W'(NV_INIT))) u_store (
    .clk(clk), .rst_n(rst_n), .sel_s_i(sel_s_w), .inc_s_i(inc_s_w),
    .pos_i(wiper_pos_o), .nv_o(nv_w), .sel_rise_o(sel_rise_w),
    .store_go_o(store_go_w), .active_o(active_w), .busy_o(busy_o),
    .standby_o(standby_o)
  );

  pw_step_ctrl #(.POS_W(POS_W)) u_step (
    .clk(clk), .rst_n(rst_n), .inc_s_i(inc_s_w), .up_s_i(up_s_w),
    .active_i(active_w), .recall_i(nv_w), .fall_o(inc_fall_w),
    .pos_next_o(pos_next_w), .pos_o(wiper_pos_o)
  );

  pw_tap_decode #(.POS_W(POS_W)) u_tap (
    .clk(clk), .pos_next_i(pos_next_w), .tap_o(tap_sel_o)
  );
endmodule

// File: rtl/pw_checker.sv
module pw_checker #(
  parameter int unsigned POS_W = 5,
  parameter int unsigned STORE_CYC = 16,
  localparam int unsigned TAPS = 1 << POS_W,
  localparam logic [POS_W-1:0] POS_MAX = '1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [POS_W-1:0] pos,
  input logic [TAPS-1:0]  tap,
  input logic             inc_fall,
  input logic             up_s,
  input logic             inc_s,
  input logic             sel_rise,
  input logic             store_go,
  input logic             busy
);
  logic [1:0]  age_q;
  logic [31:0] run_q;
  logic        live;

  always_ff @(posedge clk) begin
    if (!rst_n) age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end
  assign live = (age_q == 2'd2);

  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= busy ? run_q + 32'd1 : 32'd0;
  end

  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n || !live)
    $countones(tap) == 1);
  a_r1_tap_pos: assert property (@(posedge clk) disable iff (!rst_n || !live)
    tap[pos] == 1'b1);
  a_r2_no_fall_hold: assert property (@(posedge clk) disable iff (!rst_n || !live)
    !inc_fall |=> $stable(pos));
  a_r3_step_up: assert property (@(posedge clk) disable iff (!rst_n || !live)
    inc_fall && up_s && pos != POS_MAX |=> pos == POS_W'($past(pos) + 1'b1));
  a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n || !live)
    inc_fall && !up_s && pos != '0 |=> pos == POS_W'($past(pos) - 1'b1));
  a_r4_hold_top: assert property (@(posedge clk) disable iff (!rst_n || !live)
    inc_fall && up_s && pos == POS_MAX |=> pos == POS_MAX);
  a_r4_hold_bottom: assert property (@(posedge clk) disable iff (!rst_n || !live)
    inc_fall && !up_s && pos == '0 |=> pos == '0);
  a_r5_busy_start: assert property (@(posedge clk) disable iff (!rst_n || !live)
    store_go |=> busy);
  a_r5_busy_len: assert property (@(posedge clk) disable iff (!rst_n || !live)
    $fell(busy) |-> run_q == STORE_CYC);
  a_r6_no_store: assert property (@(posedge clk) disable iff (!rst_n || !live)
    sel_rise && !inc_s |=> !busy);
  a_r8_busy_freeze: assert property (@(posedge clk) disable iff (!rst_n || !live)
    busy |=> $stable(pos));
endmodule

bind potwiper_ctrl pw_checker #(.POS_W(POS_W), .STORE_CYC(STORE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .pos(wiper_pos_o), .tap(tap_sel_o),
  .inc_fall(inc_fall_w), .up_s(up_s_w), .inc_s(inc_s_w),
  .sel_rise(sel_rise_w), .store_go(store_go_w), .busy(busy_o)
);

// File: tb/potwiper_ctrl_tb.sv
module potwiper_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int POS_W = 5;
  localparam int STORE_CYC = 20;
  localparam int NV_INIT = 16;

  // {up, pulses, expected position}; selection stays low across rows (R3).
  localparam logic [15:0] STEPS [8] = '{
    {1'b1, 7'd3,  8'd19},
    {1'b0, 7'd5,  8'd14},
    {1'b1, 7'd20, 8'd31},
    {1'b1, 7'd2,  8'd31},
    {1'b0, 7'd40, 8'd0},
    {1'b0, 7'd1,  8'd0},
    {1'b1, 7'd1,  8'd1},
    {1'b1, 7'd6,  8'd7}
  };

  logic clk = 1'b0;
  logic rst_n, sel_n, inc, up;
  logic [POS_W-1:0]    pos;
  logic [(1<<POS_W)-1:0] tap;
  logic busy, standby;
  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  potwiper_ctrl #(.POS_W(POS_W), .STORE_CYC(STORE_CYC), .NV_INIT(NV_INIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n), .inc_i(inc), .up_i(up),
    .wiper_pos_o(pos), .tap_sel_o(tap), .busy_o(busy), .standby_o(standby)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_pos(input string tag, input int exp);
    check({tag, " position"}, int'(pos), exp);
    check({"R1 tap for ", tag}, int'(tap), int'(32'd1 << exp));
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      inc = 1'b0; tick(4);
      inc = 1'b1; tick(4);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick(3);
    rst_n = 1'b1; tick(2);
  endtask

  initial begin
    int cnt;
    rst_n = 1'b0; sel_n = 1'b1; inc = 1'b1; up = 1'b0;
    tick(3);
    rst_n = 1'b1; tick(2);
    check_pos("R7 initial recall", NV_INIT);
    check("R8 busy after reset", int'(busy), 0);
    check("R8 standby after reset", int'(standby), 1);

    // R2: strobes while deselected do nothing
    up = 1'b1; pulse(3);
    check_pos("R2 deselected strobes", NV_INIT);

    sel_n = 1'b0; tick(4);
    check("R8 standby low when selected", int'(standby), 0);

    for (int k = 0; k < 8; k++) begin
      up = STEPS[k][15]; tick(2);
      pulse(int'(STEPS[k][14:8]));
      check_pos($sformatf("R3/R4 row %0d", k), int'(STEPS[k][7:0]));
    end

    // R6: release with strobe low (its fall steps 7 -> 8 first)
    up = 1'b1; inc = 1'b0; tick(4);
    sel_n = 1'b1;
    cnt = 0;
    for (int i = 0; i < 30; i++) begin tick(1); if (busy) cnt++; end
    check("R6 no busy on no-store release", cnt, 0);
    check_pos("R6 position kept", 8);
    check("R8 standby after no-store", int'(standby), 1);
    inc = 1'b1; tick(4);
    do_reset();
    check_pos("R7 recall ignores no-store", NV_INIT);

    // R5: store 9
    sel_n = 1'b0; tick(4);
    up = 1'b0; tick(2); pulse(7);
    check_pos("R3 down to 9", 9);
    sel_n = 1'b1;
    cnt = 0;
    for (int i = 0; i < 60; i++) begin tick(1); if (busy) cnt++; end
    check("R5 busy length", cnt, STORE_CYC);
    check("R8 standby after store", int'(standby), 1);
    do_reset();
    check_pos("R5/R7 recall stored", 9);

    // R8: activity during busy is ignored
    sel_n = 1'b0; tick(4);
    up = 1'b1; tick(2); pulse(1);
    sel_n = 1'b1; tick(3);
    check("R5 busy raised", int'(busy), 1);
    sel_n = 1'b0; tick(3);
    inc = 1'b0; tick(3);
    inc = 1'b1; tick(3);
    check("R8 still busy", int'(busy), 1);
    check_pos("R8 frozen during busy", 10);
    tick(STORE_CYC);
    check("R8 selected after busy", int'(standby), 0);
    sel_n = 1'b1; tick(STORE_CYC + 10);
    do_reset();
    check_pos("R7 recall after busy", 10);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule